// File: doc/BRIEF.md
# Systolic FIR Filter with Stationary Accumulators

This block computes a finite impulse response filter on a linear array of identical multiply-accumulate cells. Each cell owns one output value at a time and keeps its running sum in place. Samples march through the array one cell per step. Coefficients march the same way but take two steps per cell, because each cell holds a coefficient for two registers. That speed difference lines each cell up with a new sample and the next coefficient on every step, so every cell does useful work on every step.

The caller feeds the coefficient set repeatedly, one coefficient per step, and raises a start flag on the first coefficient of each round. That flag moves with the coefficients. When it reaches a cell, the cell loads its finished sum into a result chain running alongside the array, and it starts its next sum from the product of the same step. The result chain delivers the sums at the far end in output-index order, one per step, each marked by a valid flag. Nothing in the array moves on a cycle where the sample input is not valid.

Top module: `sfir_resident`

## Requirements
- R1: During reset, and for the first 2·TAPS accepted steps after it, `resultValid` is 0.
- R2: Steps are counted from 0 after reset. Step u is a rising edge with `sampleValid` high. At that edge the caller supplies sample X[u], coefficient w[u mod TAPS], and `coefFirst` = 1 exactly when u mod TAPS = 0. Output m is Y[m] = Σ_{k=0..TAPS-1} w[k]·X[m+k], with samples and coefficients treated as signed two's complement, and it is given on `resultOut` as a signed ACC_W-bit value.
- R3: `coefFirst` marks the coefficient w[0]. A cell that sees the mark outputs its completed sum and starts its next sum with that step's product, so no step is lost between two sums.
- R4: Y[m] appears on `resultOut` with `resultValid` high in the cycle that follows step m+2·TAPS.
- R5: Once the pipeline has filled, every accepted step delivers exactly one result, and the outputs come in increasing index m with none missing.
- R6: A cell never loads its sum into a result-chain slot that already holds a result.
- R7: A cycle with `sampleValid` low changes no state. `sampleIn`, `coefIn` and `coefFirst` are ignored in such a cycle, `resultOut` keeps its value, and later outputs match those of the same stream without the gap.
- R8: The accumulator holds $clog2(TAPS) guard bits above the product width. With TAPS = 4 and 8-bit operands, four products of −128·−128 give +65536 with no wrap-around.
- R9: `resultValid` is high only in the cycle right after an accepted step, so each result is flagged once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Advances the whole array by one step |
| sampleIn | input | DATA_W | Signed sample for this step |
| coefIn | input | COEF_W | Signed coefficient for this step, repeated round-robin |
| coefFirst | input | 1 | High with the first coefficient of each round |
| resultValid | output | 1 | A new result is on `resultOut` this cycle |
| resultOut | output | ACC_W | Signed filter output |

## Verification
The bench counts accepted steps, not clock cycles. After step u it expects Y[u−2·TAPS] once u ≥ 2·TAPS, and no flag before that. It samples on the falling edge that follows each rising edge, so every expectation is tied to the step that edge accepted. Cycles with no step must leave the flag low and the output unchanged, while the bench drives random values on the other inputs in those cycles. The expected sums come from a bench function over the recorded samples and coefficients, so a result that is late, early, reordered or double-counted fails at the exact step where it is due.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;   // array takes one step this cycle
    logic freshOut;  // a step was taken on the previous edge
  } sfir_strobe_t;

endpackage

// File: rtl/sfir_cell.sv
module sfir_cell #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     advance,
  input  logic                     restart,
  input  logic signed [DATA_W-1:0] xOp,
  input  logic signed [COEF_W-1:0] wOp,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] product;
  logic signed [ACC_W-1:0]  prodWide;

  assign product  = xOp * wOp;
  assign prodWide = ACC_W'(product);

  // The sum stays resident; a restart drops the old sum (already taken
  // by the result chain) and seeds the next one with this step's product.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (advance) begin
      acc <= restart ? prodWide : acc + prodWide;
    end
  end

endmodule

// File: rtl/sfir_ctrl.sv
module sfir_ctrl
  import sfir_pkg::*;
#(
  parameter int TAPS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleValid,
  input  logic            coefFirst,
  output sfir_strobe_t    strobe,
  output logic [TAPS-1:0] cellTag,
  output logic [TAPS-1:0] cellEmit
);

  // Two tag registers per cell, matching the two coefficient registers
  logic [TAPS-1:0] tagA;
  logic [TAPS-1:0] tagB;
  logic [TAPS-1:0] primed;
  logic            freshOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagA     <= '0;
      tagB     <= '0;
      primed   <= '0;
      freshOut <= 1'b0;
    end else begin
      freshOut <= sampleValid;
      if (sampleValid) begin
        tagA   <= {tagB[TAPS-2:0], coefFirst};
        tagB   <= tagA;
        primed <= primed | tagA;
      end
    end
  end

  always_comb begin
    strobe.advance  = sampleValid;
    strobe.freshOut = freshOut;
  end

  // The first tag only starts a sum; later tags also release one.
  assign cellTag  = tagA;
  assign cellEmit = tagA & primed;

  for (genvar j = 1; j < TAPS; j++) begin : g_order_chk
    // R5: the tag reaches a cell only after it has passed the one before it
    p_emit_order_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.advance && cellEmit[j]) |-> primed[j-1]);
  end

endmodule

// File: rtl/sfir_datapath.sv
module sfir_datapath
  import sfir_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sfir_strobe_t             strobe,
  input  logic [TAPS-1:0]          cellTag,
  input  logic [TAPS-1:0]          cellEmit,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic signed [COEF_W-1:0] coefIn,
  output logic                     resultValid,
  output logic signed [ACC_W-1:0]  resultOut
);

  logic signed [DATA_W-1:0] xPipe     [TAPS];
  logic signed [COEF_W-1:0] wA        [TAPS];
  logic signed [COEF_W-1:0] wB        [TAPS];
  logic signed [ACC_W-1:0]  cellAcc   [TAPS];
  logic signed [ACC_W-1:0]  chainData [TAPS];
  logic [TAPS-1:0]          chainValid;

  // Samples: one register per cell. Coefficients: two registers per cell.
  // The result chain shifts toward the last cell on every step.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < TAPS; j++) begin
        xPipe[j]     <= '0;
        wA[j]        <= '0;
        wB[j]        <= '0;
        chainData[j] <= '0;
      end
      chainValid <= '0;
    end else if (strobe.advance) begin
      xPipe[0]      <= sampleIn;
      wA[0]         <= coefIn;
      wB[0]         <= wA[0];
      chainData[0]  <= cellEmit[0] ? cellAcc[0] : '0;
      chainValid[0] <= cellEmit[0];
      for (int j = 1; j < TAPS; j++) begin
        xPipe[j]      <= xPipe[j-1];
        wA[j]         <= wB[j-1];
        wB[j]         <= wA[j];
        chainData[j]  <= cellEmit[j] ? cellAcc[j] : chainData[j-1];
        chainValid[j] <= cellEmit[j] | chainValid[j-1];
      end
    end
  end

  for (genvar j = 0; j < TAPS; j++) begin : g_cell
    sfir_cell #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .ACC_W  (ACC_W)
    ) i_cell (
      .clk     (clk),
      .rstN    (rstN),
      .advance (strobe.advance),
      .restart (cellTag[j]),
      .xOp     (xPipe[j]),
      .wOp     (wA[j]),
      .acc     (cellAcc[j])
    );

    // R3: a released slot carries the sum the cell held before restarting
    p_emit_value_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.advance && cellEmit[j]) |=> chainData[j] == $past(cellAcc[j]));

    if (j > 0) begin : g_slot_chk
      // R6: a cell writes only into an empty slot of the chain
      p_slot_free_r6: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.advance && cellEmit[j]) |-> !chainValid[j-1]);
    end
  end

  assign resultOut   = chainData[TAPS-1];
  assign resultValid = chainValid[TAPS-1] & strobe.freshOut;

endmodule

// File: rtl/sfir_resident.sv
module sfir_resident
  import sfir_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic signed [COEF_W-1:0] coefIn,
  input  logic                     coefFirst,
  output logic                     resultValid,
  output logic signed [ACC_W-1:0]  resultOut
);

  sfir_strobe_t    strobe;
  logic [TAPS-1:0] cellTag;
  logic [TAPS-1:0] cellEmit;

  sfir_ctrl #(
    .TAPS (TAPS)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .coefFirst   (coefFirst),
    .strobe      (strobe),
    .cellTag     (cellTag),
    .cellEmit    (cellEmit)
  );

  sfir_datapath #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cellTag     (cellTag),
    .cellEmit    (cellEmit),
    .sampleIn    (sampleIn),
    .coefIn      (coefIn),
    .resultValid (resultValid),
    .resultOut   (resultOut)
  );

  // R9: a flagged result is not flagged again unless a step intervened
  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !sampleValid) |=> !resultValid);

  // R7: a stalled cycle leaves the output untouched
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(resultOut));

endmodule

// File: tb/test_sfir_resident.sv
module test_sfir_resident;

  localparam int K      = 4;
  localparam int ACC_W  = 18;
  localparam int MAXS   = 1024;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    sampleValid = 1'b0;
  logic signed [7:0]       sampleIn = '0;
  logic signed [7:0]       coefIn = '0;
  logic                    coefFirst = 1'b0;
  logic                    resultValid;
  logic signed [ACC_W-1:0] resultOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int wt [K];
  int xs [MAXS];
  int stepCnt = 0;
  string dataTag = "R2";

  always #10 clk = ~clk;

  sfir_resident #(.TAPS(K), .DATA_W(8), .COEF_W(8)) i_sfir_resident (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .coefIn      (coefIn),
    .coefFirst   (coefFirst),
    .resultValid (resultValid),
    .resultOut   (resultOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expY(input int m);
    int s = 0;
    for (int k = 0; k < K; k++) s += wt[k] * xs[m + k];
    return s;
  endfunction

  // Drive one cycle at the falling edge, check right after the next one
  task automatic stepCycle(input bit v, input int x);
    int u;
    int prevOut;
    prevOut     = int'(resultOut);
    sampleValid = v;
    if (v) begin
      sampleIn  = 8'(x);
      coefIn    = 8'(wt[stepCnt % K]);
      coefFirst = (stepCnt % K) == 0;
      xs[stepCnt] = x;
    end else begin
      sampleIn  = 8'($urandom);
      coefIn    = 8'($urandom);
      coefFirst = 1'($urandom);
    end
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      u = stepCnt;
      stepCnt++;
      if (u >= 2 * K) begin
        check(resultValid === 1'b1, "R4/R5 flag after step", longint'(resultValid), 1);
        check(int'(resultOut) == expY(u - 2 * K), dataTag, int'(resultOut), expY(u - 2 * K));
      end else begin
        check(resultValid === 1'b0, "R1 no flag while filling", longint'(resultValid), 0);
      end
    end else begin
      check(resultValid === 1'b0, "R9 no flag without step", longint'(resultValid), 0);
      check(int'(resultOut) == prevOut, "R7 output held in gap", int'(resultOut), prevOut);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    check(resultValid === 1'b0, "R1 flag low in reset", longint'(resultValid), 0);
    rstN = 1'b1;
    stepCnt = 0;
  endtask

  initial begin
    void'($urandom(32'd1733));
    @(negedge clk);

    // Run A: mixed-sign coefficients
    wt[0] = 3; wt[1] = -5; wt[2] = 7; wt[3] = -2;
    doReset();
    // R3: an impulse reads the coefficients back in reverse index order
    dataTag = "R3 impulse";
    for (int i = 0; i < 16; i++) stepCycle(1'b1, (i == 6) ? 1 : 0);
    // Random samples with random gaps
    dataTag = "R2/R7 random";
    for (int i = 0; i < 300; i++)
      stepCycle($urandom_range(0, 3) != 0, int'($urandom_range(0, 255)) - 128);
    // A long stall with the other inputs toggling
    for (int i = 0; i < 8; i++) stepCycle(1'b0, 0);
    dataTag = "R5 continuous";
    for (int i = 0; i < 40; i++) stepCycle(1'b1, int'($urandom_range(0, 255)) - 128);

    // Run B: extreme magnitudes
    for (int k = 0; k < K; k++) wt[k] = -128;
    doReset();
    dataTag = "R8 extremes";
    for (int i = 0; i < 16; i++) stepCycle(1'b1, -128);
    for (int i = 0; i < 20; i++) stepCycle(1'b1, (i % 2 == 0) ? 127 : -128);
    for (int i = 0; i < 12; i++) stepCycle(1'b1, 127);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule